// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Timer

A 16-bit free-running counter with two input-capture channels and two output-compare channels. Software programs and inspects it through a register file on a simple synchronous bus with one-cycle registered reads. Each capture input is synchronized, edge-qualified and, on the chosen edge, records the counter value and raises a flag. Each compare channel raises a flag when the counter equals its compare value and can drive a programmed level onto its output pin.

All event flags feed one registered interrupt request. Capture and compare events each have a per-channel enable and a group enable; when the group enable is set it admits both channels of that kind whatever their own enables say. Software can force either output pin to its programmed level. Two alternate modes drive the first compare pin from the second level bit: a PWM mode in which the second compare value sets the period, and a one-pulse mode started by the first capture input.

Top module: `cc_timer`

Register addresses (16-bit data): 0 control A, 1 control B, 2 channel enables, 3 status, 4 counter (read only), 5 capture 1 and 6 capture 2 (read only), 7 compare 1 and 8 compare 2. Unused addresses read 0.

## Requirements
- R1: While `rst` is high every register, the counter, both pins, `irq` and `rd_data` are held at zero.
- R2: The counter advances by one each clock; from FFFFh it goes to 0000h and sets the overflow flag (status bit 4), unless a mode restart happens in that cycle.
- R3: Each capture input passes two synchronizing flops; the selected edge (control A bit 1 for channel 1, control B bit 4 for channel 2; 1 = rising, 0 = falling) copies the counter into the capture register and sets status bit 0 (channel 1) or bit 1 (channel 2), at the third rising clock edge after the pin changes.
- R4: When the counter equals compare 1 (or 2), status bit 2 (or 3) is set on that edge; in normal mode, if control B bit 0 (or bit 1) is set, the pin takes control A bit 0 (or bit 2) at the same edge.
- R5: A write to control A with bit 3 set drives the written bit 0 onto `cmp1_out` at that edge; with bit 4 set, the written bit 2 onto `cmp2_out`. Force has priority over compare and mode events; force bits read back as 0 and a write with them at 0 leaves the pins as they are.
- R6: Capture interrupt: with control A bit 7 set, either capture flag requests; with it clear, flag 0 requests only if enable bit 0 (address 2) is set and flag 1 only if enable bit 1 is set.
- R7: Compare interrupt: with control A bit 6 set, either compare flag requests; with it clear, enable bits 2 and 3 qualify status bits 2 and 3.
- R8: The overflow flag requests an interrupt only while control A bit 5 is set.
- R9: Writing 1 to a status bit clears it, 0 leaves it; a flag set by hardware on the same edge as its clear stays set.
- R10: PWM mode (control B bit 2, priority over one-pulse): at a compare-2 match the counter restarts at 0 and `cmp1_out` takes the inverse of control A bit 2; at a compare-1 match it takes control A bit 2.
- R11: One-pulse mode (control B bit 3): the channel-1 capture edge restarts the counter at 0 and drives control A bit 2 onto `cmp1_out`; a compare-1 match then drives its inverse.
- R12: `irq` is registered: it reflects flags and enables as they stood one clock earlier.
- R13: A read returns the addressed register on `rd_data` at the edge following the request and holds it until the next read; control A, control B and enables read 8, 5 and 4 stored bits zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| cap1_in | input | 1 | Capture input, channel 1 |
| cap2_in | input | 1 | Capture input, channel 2 |
| cmp1_out | output | 1 | Compare output pin, channel 1 |
| cmp2_out | output | 1 | Compare output pin, channel 2 |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is a status clear landing on the very edge at which the hardware sets the same flag, along with the overflow wrap that only occurs after 65536 cycles. The bench tracks the counter in its own model, loads a compare value a few counts ahead, waits until the model shows the match count and issues the clear in exactly that cycle; it also idles through one full counter period. PWM is entered only after a one-pulse trigger has restarted the counter, so that the period is short and the mode's pin sequence is seen many times.

// File: rtl/cct_pkg.sv
package cct_pkg;

  localparam int NUM_CH = 2;

  localparam int A_CTLA = 0;
  localparam int A_CTLB = 1;
  localparam int A_IEN  = 2;
  localparam int A_STAT = 3;
  localparam int A_CNT  = 4;
  localparam int A_CAP1 = 5;
  localparam int A_CAP2 = 6;
  localparam int A_CMP1 = 7;
  localparam int A_CMP2 = 8;

  localparam logic [7:0] CTLA_STORE_MASK = 8'hE7;

  typedef struct packed {
    logic cap_grp;
    logic cmp_grp;
    logic ovf_ie;
    logic frc2;
    logic frc1;
    logic lvl2;
    logic cap1_rise;
    logic lvl1;
  } ctla_t;

  typedef struct packed {
    logic cap2_rise;
    logic one_pulse;
    logic pwm;
    logic cmp2_en;
    logic cmp1_en;
  } ctlb_t;

  typedef struct packed {
    logic cmp2_ie;
    logic cmp1_ie;
    logic cap2_ie;
    logic cap1_ie;
  } ien_t;

  typedef struct packed {
    logic ovf;
    logic cmp2;
    logic cmp1;
    logic cap2;
    logic cap1;
  } flags_t;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_PWM    = 2'd1,
    MODE_PULSE  = 2'd2
  } mode_e;

endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign wrap = (cnt == CNT_TOP) && !restart;
endmodule

// File: rtl/cct_capture_ch.sv
module cct_capture_ch #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic             rise_sel,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic [CNT_W-1:0] cap_val
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], pin};
      prev_q <= sync_q[MSB];
    end
  end

  assign cur = sync_q[MSB];
  assign hit = (cur != prev_q) && (cur == rise_sel);

  always_ff @(posedge clk) begin
    if (rst)      cap_val <= '0;
    else if (hit) cap_val <= cnt;
  end
endmodule

// File: rtl/cct_drive.sv
module cct_drive
  import cct_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic  lvl1,
  input  logic  lvl2,
  input  logic  cmp1_en,
  input  logic  cmp2_en,
  input  logic  frc1,
  input  logic  frc2,
  input  logic  frc_lvl1,
  input  logic  frc_lvl2,
  input  logic  match1,
  input  logic  match2,
  input  logic  trig,
  output logic  pin1,
  output logic  pin2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin1 <= 1'b0;
    end else if (frc1) begin
      pin1 <= frc_lvl1;
    end else begin
      case (mode)
        MODE_PWM: begin
          if (match2)      pin1 <= ~lvl2;
          else if (match1) pin1 <= lvl2;
        end
        MODE_PULSE: begin
          if (trig)        pin1 <= lvl2;
          else if (match1) pin1 <= ~lvl2;
        end
        default: begin
          if (match1 && cmp1_en) pin1 <= lvl1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     pin2 <= 1'b0;
    else if (frc2)               pin2 <= frc_lvl2;
    else if (match2 && cmp2_en)  pin2 <= lvl2;
  end
endmodule

// File: rtl/cct_regs.sv
module cct_regs
  import cct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [CNT_W-1:0]             wr_data,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cap_val,
  input  flags_t                       set_f,
  output ctla_t                        ctla,
  output ctlb_t                        ctlb,
  output ien_t                         ien,
  output flags_t                       flags,
  output logic [CNT_W-1:0]             cmp1_val,
  output logic [CNT_W-1:0]             cmp2_val,
  output logic                         frc1,
  output logic                         frc2,
  output logic                         frc_lvl1,
  output logic                         frc_lvl2,
  output logic [CNT_W-1:0]             rd_data,
  output logic                         irq
);
  localparam int CTLB_W = $bits(ctlb_t);
  localparam int IEN_W  = $bits(ien_t);
  localparam int FLG_W  = $bits(flags_t);

  ctla_t            wa;
  logic             wr_a, wr_b, wr_i, wr_s, wr_c1, wr_c2;
  flags_t           clr_f;
  logic [CNT_W-1:0] rd_next;
  logic             cap_req, cmp_req, ovf_req;

  assign wa    = ctla_t'(wr_data[7:0]);
  assign wr_a  = wr_en && (addr == ADDR_W'(A_CTLA));
  assign wr_b  = wr_en && (addr == ADDR_W'(A_CTLB));
  assign wr_i  = wr_en && (addr == ADDR_W'(A_IEN));
  assign wr_s  = wr_en && (addr == ADDR_W'(A_STAT));
  assign wr_c1 = wr_en && (addr == ADDR_W'(A_CMP1));
  assign wr_c2 = wr_en && (addr == ADDR_W'(A_CMP2));

  assign frc1     = wr_a && wa.frc1;
  assign frc2     = wr_a && wa.frc2;
  assign frc_lvl1 = wa.lvl1;
  assign frc_lvl2 = wa.lvl2;

  assign clr_f = wr_s ? flags_t'(wr_data[FLG_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctla     <= '0;
      ctlb     <= '0;
      ien      <= '0;
      cmp1_val <= '0;
      cmp2_val <= '0;
    end else begin
      if (wr_a)  ctla     <= ctla_t'(wr_data[7:0] & CTLA_STORE_MASK);
      if (wr_b)  ctlb     <= ctlb_t'(wr_data[CTLB_W-1:0]);
      if (wr_i)  ien      <= ien_t'(wr_data[IEN_W-1:0]);
      if (wr_c1) cmp1_val <= wr_data;
      if (wr_c2) cmp2_val <= wr_data;
    end
  end

  // hardware set wins over a simultaneous write-one clear
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_f) | set_f;
  end

  always_comb begin
    cap_req = ctla.cap_grp ? (flags.cap1 | flags.cap2)
                           : ((flags.cap1 & ien.cap1_ie) | (flags.cap2 & ien.cap2_ie));
    cmp_req = ctla.cmp_grp ? (flags.cmp1 | flags.cmp2)
                           : ((flags.cmp1 & ien.cmp1_ie) | (flags.cmp2 & ien.cmp2_ie));
    ovf_req = ctla.ovf_ie & flags.ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= cap_req | cmp_req | ovf_req;
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(A_CTLA): rd_next[7:0]        = ctla;
      ADDR_W'(A_CTLB): rd_next[CTLB_W-1:0] = ctlb;
      ADDR_W'(A_IEN):  rd_next[IEN_W-1:0]  = ien;
      ADDR_W'(A_STAT): rd_next[FLG_W-1:0]  = flags;
      ADDR_W'(A_CNT):  rd_next             = cnt;
      ADDR_W'(A_CAP1): rd_next             = cap_val[0];
      ADDR_W'(A_CAP2): rd_next             = cap_val[1];
      ADDR_W'(A_CMP1): rd_next             = cmp1_val;
      ADDR_W'(A_CMP2): rd_next             = cmp2_val;
      default:         rd_next             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap1_in,
  input  logic              cap2_in,
  output logic              cmp1_out,
  output logic              cmp2_out,
  output logic              irq
);
  logic [CNT_W-1:0]             cnt;
  logic                         wrap;
  logic                         restart;
  logic [NUM_CH-1:0]            cap_pin, cap_rise, cap_hit;
  logic [NUM_CH-1:0][CNT_W-1:0] cap_val;
  ctla_t                        ctla;
  ctlb_t                        ctlb;
  ien_t                         ien;
  flags_t                       flags, set_f;
  logic [CNT_W-1:0]             cmp1_val, cmp2_val;
  logic                         frc1, frc2, frc_lvl1, frc_lvl2;
  logic                         match1, match2;
  logic                         pwm_on;
  mode_e                        mode;

  always_comb begin
    if (ctlb.pwm)            mode = MODE_PWM;
    else if (ctlb.one_pulse) mode = MODE_PULSE;
    else                     mode = MODE_NORMAL;
  end

  assign pwm_on  = (mode == MODE_PWM);
  assign match1  = (cnt == cmp1_val);
  assign match2  = (cnt == cmp2_val);
  assign restart = (pwm_on && match2) || ((mode == MODE_PULSE) && cap_hit[0]);

  cct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .cnt     (cnt),
    .wrap    (wrap)
  );

  assign cap_pin  = {cap2_in, cap1_in};
  assign cap_rise = {ctlb.cap2_rise, ctla.cap1_rise};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cap
    cct_capture_ch #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .pin      (cap_pin[g]),
      .rise_sel (cap_rise[g]),
      .cnt      (cnt),
      .hit      (cap_hit[g]),
      .cap_val  (cap_val[g])
    );
  end

  always_comb begin
    set_f      = '0;
    set_f.cap1 = cap_hit[0];
    set_f.cap2 = cap_hit[1];
    set_f.cmp1 = match1;
    set_f.cmp2 = match2;
    set_f.ovf  = wrap;
  end

  cct_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .cnt      (cnt),
    .cap_val  (cap_val),
    .set_f    (set_f),
    .ctla     (ctla),
    .ctlb     (ctlb),
    .ien      (ien),
    .flags    (flags),
    .cmp1_val (cmp1_val),
    .cmp2_val (cmp2_val),
    .frc1     (frc1),
    .frc2     (frc2),
    .frc_lvl1 (frc_lvl1),
    .frc_lvl2 (frc_lvl2),
    .rd_data  (rd_data),
    .irq      (irq)
  );

  cct_drive u_drive (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .lvl1     (ctla.lvl1),
    .lvl2     (ctla.lvl2),
    .cmp1_en  (ctlb.cmp1_en),
    .cmp2_en  (ctlb.cmp2_en),
    .frc1     (frc1),
    .frc2     (frc2),
    .frc_lvl1 (frc_lvl1),
    .frc_lvl2 (frc_lvl2),
    .match1   (match1),
    .match2   (match2),
    .trig     (cap_hit[0]),
    .pin1     (cmp1_out),
    .pin2     (cmp2_out)
  );
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cnt,
  input logic              restart,
  input logic [4:0]        flags,
  input logic [7:0]        ctla,
  input logic [3:0]        ien,
  input logic [CNT_W-1:0]  cmp2_val,
  input logic              pwm_on,
  input logic [1:0]        cap_hit,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic              cmp1_out,
  input logic              irq
);
  logic req;
  always_comb begin
    req = (ctla[7] ? (flags[0] | flags[1]) : ((flags[0] & ien[0]) | (flags[1] & ien[1])))
        | (ctla[6] ? (flags[2] | flags[3]) : ((flags[2] & ien[2]) | (flags[3] & ien[3])))
        | (ctla[5] & flags[4]);
  end

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!restart && cnt != '1) |=> cnt == $past(cnt) + 1'b1);

  assert_wrap_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (!restart && cnt == '1) |=> (cnt == '0 && flags[4]));

  assert_capture_flag_R3: assert property (@(posedge clk) disable iff (rst)
    cap_hit[0] |=> flags[0]);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (cap_hit[1] && wr_en && addr == ADDR_W'(3) && wr_data[1]) |=> flags[1]);

  assert_force_pin_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(0) && wr_data[3]) |=> cmp1_out == $past(wr_data[0]));

  assert_pwm_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (pwm_on && cnt == cmp2_val) |=> cnt == '0);

  assert_irq_follow_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(req));
endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt      (cnt),
  .restart  (restart),
  .flags    (flags),
  .ctla     (ctla),
  .ien      (ien),
  .cmp2_val (cmp2_val),
  .pwm_on   (pwm_on),
  .cap_hit  (cap_hit),
  .wr_en    (wr_en),
  .addr     (addr),
  .wr_data  (wr_data),
  .cmp1_out (cmp1_out),
  .irq      (irq)
);

// File: tb/cc_timer_bench.sv
`timescale 1ns/100ps
module cc_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        cap1_in = 1'b0, cap2_in = 1'b0;
  logic        cmp1_out, cmp2_out, irq;

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  cc_timer u_cc_timer (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cap1_in(cap1_in), .cap2_in(cap2_in),
    .cmp1_out(cmp1_out), .cmp2_out(cmp2_out), .irq(irq)
  );

  // behavioural reference model
  logic [15:0] m_cnt, m_cap1, m_cap2, m_c1, m_c2, m_rd;
  logic [7:0]  m_a;
  logic [4:0]  m_b, m_f;
  logic [3:0]  m_e;
  logic        m_irq, m_o1, m_o2;
  logic [2:0]  m_p1, m_p2;   // {prev, stage2, stage1}
  logic        e1, e2, pwm, pulse, hm1, hm2, rs, ov;
  logic [4:0]  clr;

  function automatic logic irq_of(logic [4:0] f, logic [7:0] a, logic [3:0] e);
    logic c, k;
    c = a[7] ? (f[0] || f[1]) : ((f[0] && e[0]) || (f[1] && e[1]));
    k = a[6] ? (f[2] || f[3]) : ((f[2] && e[2]) || (f[3] && e[3]));
    return c || k || (a[5] && f[4]);
  endfunction

  function automatic logic [15:0] read_of(logic [3:0] a);
    case (a)
      4'd0: return {8'h00, m_a};
      4'd1: return {11'h000, m_b};
      4'd2: return {12'h000, m_e};
      4'd3: return {11'h000, m_f};
      4'd4: return m_cnt;
      4'd5: return m_cap1;
      4'd6: return m_cap2;
      4'd7: return m_c1;
      4'd8: return m_c2;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cap1 = 0; m_cap2 = 0; m_c1 = 0; m_c2 = 0; m_rd = 0;
      m_a = 0; m_b = 0; m_f = 0; m_e = 0; m_irq = 0; m_o1 = 0; m_o2 = 0;
      m_p1 = 0; m_p2 = 0;
    end else begin
      e1 = (m_p1[1] != m_p1[2]) && (m_p1[1] == m_a[1]);
      e2 = (m_p2[1] != m_p2[2]) && (m_p2[1] == m_b[4]);
      pwm = m_b[2];
      pulse = m_b[3] && !m_b[2];
      hm1 = (m_cnt == m_c1);
      hm2 = (m_cnt == m_c2);
      rs = (pwm && hm2) || (pulse && e1);
      ov = (m_cnt == 16'hFFFF) && !rs;
      clr = (wr_en && addr == 4'd3) ? wr_data[4:0] : 5'd0;
      m_irq = irq_of(m_f, m_a, m_e);
      if (rd_en) m_rd = read_of(addr);
      // pin 1
      if (wr_en && addr == 4'd0 && wr_data[3]) m_o1 = wr_data[0];
      else if (pwm) begin
        if (hm2) m_o1 = !m_a[2]; else if (hm1) m_o1 = m_a[2];
      end else if (pulse) begin
        if (e1) m_o1 = m_a[2]; else if (hm1) m_o1 = !m_a[2];
      end else if (hm1 && m_b[0]) m_o1 = m_a[0];
      // pin 2
      if (wr_en && addr == 4'd0 && wr_data[4]) m_o2 = wr_data[2];
      else if (hm2 && m_b[1]) m_o2 = m_a[2];
      if (e1) m_cap1 = m_cnt;
      if (e2) m_cap2 = m_cnt;
      m_f = (m_f & ~clr) | {ov, hm2, hm1, e2, e1};
      m_cnt = rs ? 16'h0000 : m_cnt + 16'h0001;
      if (wr_en) begin
        case (addr)
          4'd0: m_a = wr_data[7:0] & 8'hE7;
          4'd1: m_b = wr_data[4:0];
          4'd2: m_e = wr_data[3:0];
          4'd7: m_c1 = wr_data;
          4'd8: m_c2 = wr_data;
          default: ;
        endcase
      end
      m_p1 = {m_p1[1:0], cap1_in};
      m_p2 = {m_p2[1:0], cap2_in};
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      compared++;
      if (rd_data !== m_rd || irq !== m_irq || cmp1_out !== m_o1 || cmp2_out !== m_o2) begin
        mismatched++;
        $display("FAIL %s: rd_data=%h irq=%b cmp1=%b cmp2=%b expected rd_data=%h irq=%b cmp1=%b cmp2=%b",
                 tag, rd_data, irq, cmp1_out, cmp2_out, m_rd, m_irq, m_o1, m_o2);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    logic [15:0] tgt;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    tag = "R1";
    for (int i = 0; i < 9; i++) rd(4'(i));

    tag = "R13";
    wr(4'd7, 16'h1234); wr(4'd8, 16'hABCD); wr(4'd2, 16'h000F);
    wr(4'd0, 16'h00FF); wr(4'd1, 16'h0013);
    for (int i = 0; i < 10; i++) rd(4'(i));
    idle(2);
    wr(4'd0, 16'h0000); wr(4'd1, 16'h0000); wr(4'd2, 16'h0000);

    tag = "R2";
    rd(4'd4); idle(3); rd(4'd4);
    wr(4'd3, 16'h001F);
    idle(65540);
    rd(4'd3);

    tag = "R8";
    wr(4'd0, 16'h0020); idle(3); rd(4'd3);
    wr(4'd0, 16'h0000); idle(3);

    tag = "R9";
    wr(4'd3, 16'h001F);
    tgt = m_cnt + 16'd20;
    wr(4'd7, tgt);
    while (m_cnt != tgt) @(negedge clk);
    wr(4'd3, 16'h0004);
    rd(4'd3);
    wr(4'd3, 16'h0004); rd(4'd3);

    tag = "R3";
    wr(4'd0, 16'h0002); wr(4'd1, 16'h0000); wr(4'd3, 16'h001F);
    cap1_in = 1'b1; idle(6); rd(4'd5); rd(4'd3);
    cap2_in = 1'b1; idle(5); cap2_in = 1'b0; idle(6); rd(4'd6); rd(4'd3);
    wr(4'd0, 16'h0000); cap1_in = 1'b0; idle(6); rd(4'd5);

    tag = "R6";
    wr(4'd3, 16'h001F); wr(4'd2, 16'h0001);
    cap2_in = 1'b1; idle(5); cap2_in = 1'b0; idle(6);
    wr(4'd0, 16'h0080); idle(3);
    wr(4'd0, 16'h0000); wr(4'd2, 16'h0002); idle(3);
    wr(4'd2, 16'h0000); wr(4'd3, 16'h001F); idle(2);

    tag = "R7";
    wr(4'd2, 16'h0004);
    wr(4'd8, m_cnt + 16'd15); idle(25);
    wr(4'd0, 16'h0040); idle(3);
    wr(4'd0, 16'h0000); wr(4'd2, 16'h0008); idle(3);
    wr(4'd2, 16'h0000); wr(4'd3, 16'h001F); idle(2);

    tag = "R4";
    wr(4'd1, 16'h0001); wr(4'd0, 16'h0005);
    wr(4'd7, m_cnt + 16'd12); wr(4'd8, m_cnt + 16'd14);
    idle(20); rd(4'd3);

    tag = "R5";
    wr(4'd0, 16'h0008); idle(2);
    wr(4'd0, 16'h0014); idle(2);
    wr(4'd0, 16'h0001); idle(3); rd(4'd0);
    wr(4'd1, 16'h0000);

    tag = "R11";
    wr(4'd7, 16'd20); wr(4'd0, 16'h0006); wr(4'd1, 16'h0008);
    cap1_in = 1'b1; idle(40); rd(4'd4);
    cap1_in = 1'b0; idle(5);

    tag = "R10";
    wr(4'd7, 16'd10); wr(4'd8, 16'd40);
    cap1_in = 1'b1; idle(4);
    wr(4'd1, 16'h0004); idle(150); rd(4'd4);
    wr(4'd0, 16'h0002); idle(100);
    wr(4'd1, 16'h0000);

    tag = "R12";
    wr(4'd3, 16'h001F); wr(4'd0, 16'h0002);
    cap1_in = 1'b0; idle(5);
    wr(4'd2, 16'h0001); cap1_in = 1'b1; idle(6);
    wr(4'd3, 16'h0001); idle(3);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule